// File: doc/BRIEF.md
# Microprogram Sequencer with Control Store

This block steps a horizontally encoded microprogram. It holds a writable control store, a microprogram counter and a microinstruction register. Every clock cycle it forms the address of the next microinstruction, loads that word into the microinstruction register, and drives the word's control fields to a datapath. The fields are ALU/shift function, register write mask, memory operation and B-bus source select.

The counter never increments by itself. Each microinstruction names its successor. Two mechanisms modify that successor. A conditional branch ORs the datapath's negative and zero flags into the top address bit. A multiway dispatch ORs an 8-bit byte from the datapath into the low address byte. The store is filled through a preload port, and that port accepts writes only while the sequencer is held in reset.

Top module: `useq_ctrl`

## Requirements
- R1: While rst_ni is low, mpc_o is 0 and every control output is 0, which is a no-operation word with successor 0. The first rising edge after release loads the word stored at address 0 and shows mpc_o = 0.
- R2: The 36-bit word is laid out as follows. Bits [35:27] hold the successor address. Bit 26 is the dispatch enable, bit 25 is the negative-branch enable and bit 24 is the zero-branch enable. Bits [23:16] are the ALU/shift field, bits [15:7] are the write mask, bits [6:4] are the memory field (6 write, 5 read, 4 fetch) and bits [3:0] are the B select. Each field appears unchanged on its own output.
- R3: One microinstruction executes per cycle. After each rising edge, mpc_o shows the newly formed address and the control outputs show the stored word at that address.
- R4: With bits 26..24 all zero, the next address equals bits [35:27] exactly, whatever the values of n_i, z_i and mbr_i.
- R5: The top address bit becomes bit 35 OR (bit 24 AND z_i) OR (bit 25 AND n_i). A branch therefore chooses between an address and that address plus 0x100.
- R6: With bit 26 set, the low 8 address bits become bits [34:27] OR mbr_i. With bit 26 clear, mbr_i has no effect.
- R7: A preload write issued while rst_ni is high leaves the store unchanged. This is observed when the targeted word is executed.
- R8: All 512 words are independently addressable. A chain that visits every address shows each address's own preloaded word.
- R9: n_i, z_i and mbr_i are sampled in the cycle in which the branching microinstruction occupies the instruction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; also opens the preload port |
| ld_en_i | input | 1 | Preload write strobe |
| ld_addr_i | input | 9 | Preload address |
| ld_word_i | input | 36 | Preload microinstruction |
| mbr_i | input | 8 | Dispatch byte from the datapath |
| n_i | input | 1 | Negative flag from the datapath flag register |
| z_i | input | 1 | Zero flag from the datapath flag register |
| mpc_o | output | 9 | Address of the microinstruction in the register |
| alu_ctl_o | output | 8 | ALU and shifter control |
| c_wr_o | output | 9 | Register write mask |
| mem_op_o | output | 3 | Memory operation (write, read, fetch) |
| b_sel_o | output | 4 | B-bus source select |

## Verification
The bench builds the block at its default size: a 9-bit address, an 8-bit dispatch byte and a 512-word store. At that size every store word can be visited in a single 512-step chain, so R8 is checked exhaustively.

The branch logic is swept over every combination of the three branch-control bits and the two flags. The sweep uses four successor addresses, chosen to include both values of the top bit and overlapping low bytes, and three dispatch bytes. Expected addresses come from the bit formulas in R5 and R6.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int JAM_W  = 3;
  localparam int MEM_W  = 3;
  localparam int JMPC_B = 2;
  localparam int JAMN_B = 1;
  localparam int JAMZ_B = 0;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 36,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int ADDR_W = 9,
  localparam int DISP_W = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] succ_i,
  input  logic [JAM_W-1:0]  jam_i,
  input  logic              n_i,
  input  logic              z_i,
  input  logic [DISP_W-1:0] mbr_i,
  output logic [ADDR_W-1:0] mpc_d_o
);
  logic hi_bit;
  assign hi_bit = succ_i[ADDR_W-1] | (jam_i[JAMZ_B] & z_i) | (jam_i[JAMN_B] & n_i);

  // per-bit dispatch merge
  for (genvar i = 0; i < DISP_W; i++) begin : g_disp
    assign mpc_d_o[i] = succ_i[i] | (jam_i[JMPC_B] & mbr_i[i]);
  end
  assign mpc_d_o[ADDR_W-1] = hi_bit;
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int ALU_W   = 8,
  parameter int CMASK_W = 9,
  parameter int BSEL_W  = 4,
  localparam int DISP_W = ADDR_W - 1,
  localparam int WORD_W = ADDR_W + JAM_W + ALU_W + CMASK_W + MEM_W + BSEL_W,
  localparam int BSEL_LO  = 0,
  localparam int MEM_LO   = BSEL_LO + BSEL_W,
  localparam int CMASK_LO = MEM_LO + MEM_W,
  localparam int ALU_LO   = CMASK_LO + CMASK_W,
  localparam int JAM_LO   = ALU_LO + ALU_W,
  localparam int SUCC_LO  = JAM_LO + JAM_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_en_i,
  input  logic [ADDR_W-1:0]  ld_addr_i,
  input  logic [WORD_W-1:0]  ld_word_i,
  input  logic [DISP_W-1:0]  mbr_i,
  input  logic               n_i,
  input  logic               z_i,
  output logic [ADDR_W-1:0]  mpc_o,
  output logic [ALU_W-1:0]   alu_ctl_o,
  output logic [CMASK_W-1:0] c_wr_o,
  output logic [MEM_W-1:0]   mem_op_o,
  output logic [BSEL_W-1:0]  b_sel_o
);
  logic [ADDR_W-1:0] mpc_q, mpc_d;
  logic [WORD_W-1:0] mir_q, rd_word;
  logic [ADDR_W-1:0] succ;
  logic [JAM_W-1:0]  jam;

  assign succ = mir_q[SUCC_LO +: ADDR_W];
  assign jam  = mir_q[JAM_LO +: JAM_W];

  useq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (ld_en_i & ~rst_ni),  // preload only while held in reset
    .waddr_i (ld_addr_i),
    .wdata_i (ld_word_i),
    .raddr_i (mpc_d),
    .rdata_o (rd_word)
  );

  useq_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .succ_i  (succ),
    .jam_i   (jam),
    .n_i     (n_i),
    .z_i     (z_i),
    .mbr_i   (mbr_i),
    .mpc_d_o (mpc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mpc_q <= '0;
      mir_q <= '0;
    end else begin
      mpc_q <= mpc_d;
      mir_q <= rd_word;
    end
  end

  assign mpc_o     = mpc_q;
  assign alu_ctl_o = mir_q[ALU_LO +: ALU_W];
  assign c_wr_o    = mir_q[CMASK_LO +: CMASK_W];
  assign mem_op_o  = mir_q[MEM_LO +: MEM_W];
  assign b_sel_o   = mir_q[BSEL_LO +: BSEL_W];

  a_r4_plain_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jam == '0) |=> (mpc_q == $past(succ)));

  a_r5_flag_sets_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((jam[JAMZ_B] && z_i) || (jam[JAMN_B] && n_i)) |=> mpc_q[ADDR_W-1]);

  a_r5_no_cond_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jam[JAMZ_B] && !jam[JAMN_B]) |=> (mpc_q[ADDR_W-1] == $past(succ[ADDR_W-1])));

  a_r6_no_dispatch_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jam[JMPC_B] |=> (mpc_q[DISP_W-1:0] == $past(succ[DISP_W-1:0])));

  a_r6_dispatch_covers_mbr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jam[JMPC_B] |=> ((mpc_q[DISP_W-1:0] & $past(mbr_i)) == $past(mbr_i)));
endmodule

// File: tb/tb_useq_ctrl.sv
module tb_useq_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_en = 1'b0;
  logic [8:0]  ld_addr = '0;
  logic [35:0] ld_word = '0;
  logic [7:0]  mbr = '0;
  logic        n = 1'b0, z = 1'b0;
  logic [8:0]  mpc_o;
  logic [7:0]  alu_ctl_o;
  logic [8:0]  c_wr_o;
  logic [2:0]  mem_op_o;
  logic [3:0]  b_sel_o;

  int total = 0, bad = 0;
  logic [35:0] model [512];

  always #(CLK_P/2) clk = ~clk;

  useq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .ld_en_i(ld_en), .ld_addr_i(ld_addr),
    .ld_word_i(ld_word), .mbr_i(mbr), .n_i(n), .z_i(z), .mpc_o(mpc_o),
    .alu_ctl_o(alu_ctl_o), .c_wr_o(c_wr_o), .mem_op_o(mem_op_o), .b_sel_o(b_sel_o)
  );

  function automatic logic [35:0] sig(input int a);
    logic [8:0] av;
    av = a[8:0];
    return {av + 9'd1, 3'b000, av[7:0] ^ 8'hC3, ~av, av[2:0], av[3:0] ^ 4'h9};
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // R2: field positions of the stored word
  task automatic check_out(input string tag, input logic [8:0] addr);
    chk({tag, " mpc"}, {27'd0, mpc_o}, {27'd0, addr});
    chk({tag, " R2 fields"}, {12'd0, alu_ctl_o, c_wr_o, mem_op_o, b_sel_o},
        {12'd0, model[addr][23:0]});
  endtask

  task automatic load(input logic [8:0] a, input logic [35:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_word = w;
    if (!rst_ni) model[a] = w;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", {3'd0, mpc_o, alu_ctl_o, c_wr_o, mem_op_o, b_sel_o}, 36'd0);

    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = a[8:0]; ld_word = sig(a);
      model[a] = sig(a);
    end
    @(negedge clk);
    ld_en = 1'b0;
    n = 1'b1; z = 1'b1; mbr = 8'hFF;  // R4: ignored, no branch bits in chain
    rst_ni = 1'b1;
    @(negedge clk);
    check_out("R1 first word", 9'd0);
    // R7: write attempt while running must be dropped
    ld_en = 1'b1; ld_addr = 9'd300; ld_word = 36'hF_FFFF_FFFF;
    @(negedge clk);
    ld_en = 1'b0;
    check_out("R3 step", 9'd1);
    for (int i = 2; i < 520; i++) begin
      @(negedge clk);
      if ((i % 512) == 300) check_out("R7 run write ignored", 9'd300);
      else check_out("R8 chain", 9'(i % 512));
    end

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset", {3'd0, mpc_o, alu_ctl_o, c_wr_o, mem_op_o, b_sel_o}, 36'd0);

    // branch sweep; R9: flags and byte applied while word 0 is in the register
    for (int j = 0; j < 8; j++) begin
      for (int f = 0; f < 4; f++) begin
        for (int s = 0; s < 4; s++) begin
          for (int m = 0; m < 3; m++) begin
            logic [8:0] nx, ex;
            logic [7:0] mv;
            logic [2:0] jv;
            string tag;
            nx = (s == 0) ? 9'h000 : (s == 1) ? 9'h0A5 : (s == 2) ? 9'h155 : 9'h1FF;
            mv = (m == 0) ? 8'h00 : (m == 1) ? 8'h5A : 8'hFF;
            jv = j[2:0];
            rst_ni = 1'b0;
            n = 1'b0; z = 1'b0; mbr = 8'h00;
            load(9'd0, {nx, jv, 8'h3C, 9'h0F0, 3'b101, 4'h6});
            rst_ni = 1'b1;
            @(negedge clk);
            check_out("R3 dispatch word", 9'd0);
            n = f[1]; z = f[0]; mbr = mv;
            ex[8] = nx[8] | (jv[0] & f[0]) | (jv[1] & f[1]);
            ex[7:0] = jv[2] ? (nx[7:0] | mv) : nx[7:0];
            tag = (jv == 3'd0) ? "R4 plain" : jv[2] ? "R6 dispatch R9" : "R5 cond R9";
            @(negedge clk);
            check_out(tag, ex);
          end
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule